// File: doc/BRIEF.md
# DRAM Write-to-Read Turnaround Timer

This block sits in the command path of a DDR3-style memory controller. It watches every WRITE that goes to a device and works out the first clock on which a READ to that same device may go out. The hold-off is measured from the end of the write data burst, not from the WRITE command itself. A WRITE at cycle t therefore blocks READs to its device until cycle t + AL + CWL + tBL + tWTR. Every device has its own countdown, so a WRITE never holds back READs to the other devices.

A mode-register burst field and address bit A12 of each command together pick a 4-beat chop or a full 8-beat burst. The decoded choice is shown on an output, and it selects the burst-window length used for that WRITE. The AL, CWL, CL and tWTR values come in as run-time inputs. They are latched only while no countdown is running. For each accepted READ, the block reports the cycle of a free-running counter on which read data is due. A READ presented too early is refused and flagged.

Top module: `wtr_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, every bit of `rd_allowed` is 1, `rd_violation` and `rd_due_vld` are 0, and `now_cycle` is 0.
- R2: `cmd_bc4` is 1 (4-beat chop) when `mr_bl` is 2'b10, or when `mr_bl` is 2'b01 and `cmd_a12` is 0. In every other case it is 0 (8-beat burst). This covers `mr_bl` 2'b00, 2'b11, and 2'b01 with `cmd_a12` at 1.
- R3: A WRITE (`cmd_op` 2'b01) to device d that is sampled at edge t makes `rd_allowed[d]` 0 from the cycle after t up to and including cycle t+D-1, where D = AL+CWL+tBL+tWTR. `rd_allowed[d]` returns to 1 in cycle t+D.
- R4: The burst window tBL is 4 clocks for both a chopped and a full burst, so BC4 and BL8 WRITEs give the same turnaround.
- R5: A WRITE to one device has no effect on `rd_allowed` for any other device.
- R6: A READ (`cmd_op` 2'b10) to a device whose `rd_allowed` bit is 1 raises `rd_due_vld` for one cycle, starting the next cycle. At the same time `rd_due_cyc` equals the `now_cycle` value of the READ cycle plus AL+CL.
- R7: A READ to a device whose `rd_allowed` bit is 0 gives a one-cycle `rd_violation` pulse the next cycle and no `rd_due_vld`, and it leaves the countdown unchanged.
- R8: A new WRITE to a device restarts that device's countdown from its own timing, even if an older countdown is still running.
- R9: The AL, CWL, CL and tWTR inputs are latched only on edges where no device is counting and no WRITE is sampled. A change while a countdown runs does not affect that countdown, nor a READ accepted on the cycle the countdown ends.
- R10: `now_cycle` goes up by one on every clock edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 2 | Command: 00 none, 01 WRITE, 10 READ, 11 other |
| cmd_dev | input | 1 | Target device index (DEV_W) |
| cmd_a12 | input | 1 | Address bit A12 of the command |
| mr_bl | input | 2 | Mode-register burst-length field |
| cfg_al | input | 4 | Additive latency, clocks (LAT_W) |
| cfg_cwl | input | 4 | CAS write latency, clocks (LAT_W) |
| cfg_cl | input | 4 | CAS latency, clocks (LAT_W) |
| cfg_twtr | input | 4 | Write-to-read delay, clocks (LAT_W) |
| cmd_bc4 | output | 1 | Current command decodes to a 4-beat chop |
| rd_allowed | output | 2 | Per device: a READ is legal this cycle (N_DEV) |
| rd_violation | output | 1 | Pulse: an early READ was refused |
| rd_due_vld | output | 1 | Pulse: a READ was accepted |
| rd_due_cyc | output | 16 | Cycle on which read data is due (CYC_W) |
| now_cycle | output | 16 | Free-running cycle counter (CYC_W) |

## Verification
The bench probes the last blocked cycle and the first legal cycle of each countdown. A timer that counted from the command instead of from the burst end, or that was one cycle off, would let a READ through a cycle early or hold it a cycle too long. A WRITE re-issued halfway through a countdown catches a design that keeps the older, earlier end time. A configuration change during a countdown, followed by a READ on the very cycle the countdown ends, catches latching that happens too early. Every burst-field and A12 combination is decoded, and an early READ must be refused without pushing the countdown out.

// File: rtl/wtr_pkg.sv
package wtr_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_OTHER = 2'b11
   } cmd_op_e;

   localparam logic [1:0] BLM_FIX8 = 2'b00;
   localparam logic [1:0] BLM_OTF  = 2'b01;
   localparam logic [1:0] BLM_FIX4 = 2'b10;

   function automatic logic chop_from_mode(input logic [1:0] mode, input logic a12);
      logic r;
      case (mode)
         BLM_OTF:  r = ~a12;
         BLM_FIX4: r = 1'b1;
         default:  r = 1'b0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/wtr_bl_decode.sv
module wtr_bl_decode
   import wtr_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       a12,
   output logic       chop
);
   always_comb chop = chop_from_mode(mode, a12);
endmodule

// File: rtl/wtr_dev_timer.sv
module wtr_dev_timer #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy
);
   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remain_q <= '0;
      else if (load)             remain_q <= load_val;
      else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
   end

   assign busy = (remain_q != '0);
endmodule

// File: rtl/wtr_timer.sv
module wtr_timer
   import wtr_pkg::*;
#(
   parameter int N_DEV    = 2,
   parameter int LAT_W    = 4,
   parameter int CYC_W    = 16,
   parameter int TBL_BC4  = 4,
   parameter int TBL_BL8  = 4,
   parameter int RST_AL   = 0,
   parameter int RST_CWL  = 5,
   parameter int RST_CL   = 5,
   parameter int RST_TWTR = 4,
   localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1,
   localparam int CNT_W   = LAT_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_op,
   input  logic [DEV_W-1:0]  cmd_dev,
   input  logic              cmd_a12,
   input  logic [1:0]        mr_bl,
   input  logic [LAT_W-1:0]  cfg_al,
   input  logic [LAT_W-1:0]  cfg_cwl,
   input  logic [LAT_W-1:0]  cfg_cl,
   input  logic [LAT_W-1:0]  cfg_twtr,
   output logic              cmd_bc4,
   output logic [N_DEV-1:0]  rd_allowed,
   output logic              rd_violation,
   output logic              rd_due_vld,
   output logic [CYC_W-1:0]  rd_due_cyc,
   output logic [CYC_W-1:0]  now_cycle
);
   // elaboration-time parameter checks
   if (N_DEV < 1)                       begin : g_bad_ndev $error("N_DEV must be at least 1"); end
   if (TBL_BC4 < 1 || TBL_BL8 < 1)     begin : g_bad_tbl  $error("burst windows must be at least 1"); end
   if (TBL_BC4 >= (1 << LAT_W) || TBL_BL8 >= (1 << LAT_W))
                                        begin : g_big_tbl  $error("burst windows must fit LAT_W"); end
   if (CYC_W < 2)                       begin : g_bad_cyc  $error("CYC_W too small"); end

   logic [LAT_W-1:0] al_q, cwl_q, cl_q, twtr_q;
   logic [CYC_W-1:0] cyc_q;
   logic [N_DEV-1:0] busy;
   logic [CNT_W-1:0] tbl_sel;
   logic [CNT_W-1:0] gap_m1;
   logic             is_wr, is_rd, dev_ok;

   wtr_bl_decode u_dec (
      .mode (mr_bl),
      .a12  (cmd_a12),
      .chop (cmd_bc4)
   );

   // burst-window choice: a constant when both lengths match
   if (TBL_BC4 == TBL_BL8) begin : g_tbl_same
      assign tbl_sel = CNT_W'(TBL_BL8);
   end else begin : g_tbl_mux
      assign tbl_sel = cmd_bc4 ? CNT_W'(TBL_BC4) : CNT_W'(TBL_BL8);
   end

   assign is_wr  = (cmd_op == OP_WRITE);
   assign is_rd  = (cmd_op == OP_READ);
   assign gap_m1 = CNT_W'(al_q) + CNT_W'(cwl_q) + tbl_sel + CNT_W'(twtr_q) - 1'b1;

   for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      logic hit;
      assign hit = is_wr && (cmd_dev == DEV_W'(d));
      wtr_dev_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (hit),
         .load_val (gap_m1),
         .busy     (busy[d])
      );
      assign rd_allowed[d] = ~busy[d];
   end

   always_comb begin
      dev_ok = 1'b0;
      for (int d = 0; d < N_DEV; d++)
         if (cmd_dev == DEV_W'(d)) dev_ok = rd_allowed[d];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_q   <= LAT_W'(RST_AL);
         cwl_q  <= LAT_W'(RST_CWL);
         cl_q   <= LAT_W'(RST_CL);
         twtr_q <= LAT_W'(RST_TWTR);
      end else if (!(|busy) && !is_wr) begin
         al_q   <= cfg_al;
         cwl_q  <= cfg_cwl;
         cl_q   <= cfg_cl;
         twtr_q <= cfg_twtr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q        <= '0;
         rd_due_vld   <= 1'b0;
         rd_violation <= 1'b0;
         rd_due_cyc   <= '0;
      end else begin
         cyc_q        <= cyc_q + 1'b1;
         rd_due_vld   <= is_rd && dev_ok;
         rd_violation <= is_rd && !dev_ok;
         if (is_rd && dev_ok)
            rd_due_cyc <= cyc_q + CYC_W'(al_q) + CYC_W'(cl_q);
      end
   end

   assign now_cycle = cyc_q;
endmodule

// File: rtl/wtr_timer_chk.sv
module wtr_timer_chk #(
   parameter int N_DEV = 2,
   parameter int DEV_W = 1,
   parameter int CYC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cmd_op,
   input logic [DEV_W-1:0] cmd_dev,
   input logic [N_DEV-1:0] rd_allowed,
   input logic             rd_violation,
   input logic             rd_due_vld,
   input logic [CYC_W-1:0] now_cycle
);
   assert_reset_open_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (&rd_allowed && !rd_violation && !rd_due_vld));

   for (genvar d = 0; d < N_DEV; d++) begin : g_chk
      assert_write_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_op == 2'b01 && cmd_dev == DEV_W'(d)) |=> !rd_allowed[d]);
      assert_early_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_op == 2'b10 && cmd_dev == DEV_W'(d) && !rd_allowed[d]) |=> (rd_violation && !rd_due_vld));
      assert_read_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_op == 2'b10 && cmd_dev == DEV_W'(d) && rd_allowed[d]) |=> (rd_due_vld && !rd_violation));
   end

   assert_no_read_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op != 2'b10) |=> (!rd_due_vld && !rd_violation));

   assert_cycle_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (now_cycle == $past(now_cycle) + 1'b1));
endmodule

bind wtr_timer wtr_timer_chk #(.N_DEV(N_DEV), .DEV_W(DEV_W), .CYC_W(CYC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_op       (cmd_op),
   .cmd_dev      (cmd_dev),
   .rd_allowed   (rd_allowed),
   .rd_violation (rd_violation),
   .rd_due_vld   (rd_due_vld),
   .now_cycle    (now_cycle)
);

// File: tb/wtr_timer_bench.sv
module wtr_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cmd_op = 2'b00;
   logic        cmd_dev = 1'b0;
   logic        cmd_a12 = 1'b1;
   logic [1:0]  mr_bl = 2'b00;
   logic [3:0]  cfg_al = 4'd0, cfg_cwl = 4'd5, cfg_cl = 4'd5, cfg_twtr = 4'd4;
   logic        cmd_bc4;
   logic [1:0]  rd_allowed;
   logic        rd_violation, rd_due_vld;
   logic [15:0] rd_due_cyc, now_cycle;

   int errors = 0;
   int checks = 0;
   logic [15:0] stamp;

   always #5 clk = ~clk;

   wtr_timer u_wtr_timer (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_a12(cmd_a12),
      .mr_bl(mr_bl), .cfg_al(cfg_al), .cfg_cwl(cfg_cwl), .cfg_cl(cfg_cl), .cfg_twtr(cfg_twtr),
      .cmd_bc4(cmd_bc4), .rd_allowed(rd_allowed), .rd_violation(rd_violation),
      .rd_due_vld(rd_due_vld), .rd_due_cyc(rd_due_cyc), .now_cycle(now_cycle)
   );

   // mode, a12, expected chop
   localparam logic [3:0] DEC_VEC [8] = '{
      {2'b00, 1'b0, 1'b0}, {2'b00, 1'b1, 1'b0},
      {2'b01, 1'b0, 1'b1}, {2'b01, 1'b1, 1'b0},
      {2'b10, 1'b0, 1'b1}, {2'b10, 1'b1, 1'b1},
      {2'b11, 1'b0, 1'b0}, {2'b11, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic issue(input logic [1:0] op, input logic dev);
      cmd_op = op; cmd_dev = dev;
      step(1);
      cmd_op = 2'b00;
   endtask

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      step(3);
      check("R1 allowed in reset", rd_allowed, 2'b11);
      check("R1 no violation in reset", rd_violation, 0);
      rst_n = 1'b1;
      check("R1 cycle zero", now_cycle, 0);
      check("R1 no due", rd_due_vld, 0);
      step(1);
      check("R10 cycle step", now_cycle, 1);

      // burst decode table (R2)
      for (int v = 0; v < 8; v++) begin
         mr_bl = DEC_VEC[v][3:2]; cmd_a12 = DEC_VEC[v][1];
         #1;
         check("R2 chop decode", cmd_bc4, DEC_VEC[v][0]);
      end
      mr_bl = 2'b00; cmd_a12 = 1'b1;
      step(1);

      // full burst write dev0: D = 0+5+4+4 = 13
      issue(2'b01, 1'b0);
      check("R3 blocked after write", rd_allowed[0], 0);
      check("R5 other device free", rd_allowed[1], 1);
      step(11);
      check("R3 last blocked cycle", rd_allowed[0], 0);
      step(1);
      check("R3 first legal cycle", rd_allowed[0], 1);
      stamp = now_cycle;
      issue(2'b10, 1'b0);
      check("R6 due valid", rd_due_vld, 1);
      check("R6 due cycle", rd_due_cyc, stamp + 16'd5);
      check("R6 no violation", rd_violation, 0);

      // chopped write: same gap (R4)
      mr_bl = 2'b01; cmd_a12 = 1'b0;
      issue(2'b01, 1'b0);
      step(11);
      check("R4 chop last blocked", rd_allowed[0], 0);
      step(1);
      check("R4 chop first legal", rd_allowed[0], 1);
      mr_bl = 2'b00; cmd_a12 = 1'b1;

      // early read on dev1 (R7)
      issue(2'b01, 1'b1);
      check("R5 dev0 unaffected", rd_allowed[0], 1);
      step(3);
      issue(2'b10, 1'b1);
      check("R7 violation pulse", rd_violation, 1);
      check("R7 no due", rd_due_vld, 0);
      check("R7 still blocked", rd_allowed[1], 0);
      step(7);
      check("R7 countdown not extended", rd_allowed[1], 0);
      step(1);
      check("R7 countdown not extended", rd_allowed[1], 1);
      check("R7 pulse ended", rd_violation, 0);

      // restart by newer write (R8)
      issue(2'b01, 1'b0);
      step(5);
      issue(2'b01, 1'b0);
      step(7);
      check("R8 old end ignored", rd_allowed[0], 0);
      step(4);
      check("R8 last blocked", rd_allowed[0], 0);
      step(1);
      check("R8 restart end", rd_allowed[0], 1);

      // config latch (R9): D = 1+7+4+2 = 14, RL = 7
      cfg_al = 4'd1; cfg_cwl = 4'd7; cfg_cl = 4'd6; cfg_twtr = 4'd2;
      step(2);
      issue(2'b01, 1'b0);
      cfg_al = 4'd0; cfg_cwl = 4'd5; cfg_cl = 4'd5; cfg_twtr = 4'd4;
      step(12);
      check("R9 old config held", rd_allowed[0], 0);
      step(1);
      check("R9 old config end", rd_allowed[0], 1);
      stamp = now_cycle;
      issue(2'b10, 1'b0);
      check("R9 read uses latched RL", rd_due_cyc, stamp + 16'd7);
      step(1);
      stamp = now_cycle;
      issue(2'b10, 1'b0);
      check("R9 new RL after idle", rd_due_cyc, stamp + 16'd5);

      // reset mid-countdown (R1)
      issue(2'b01, 1'b1);
      step(2);
      rst_n = 1'b0;
      step(1);
      rst_n = 1'b1;
      check("R1 reset clears pending", rd_allowed, 2'b11);
      check("R1 counter cleared", now_cycle, 0);
      step(2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule